// File: doc/BRIEF.md
# Nine-bit multiprocessor UART

This block is an asynchronous serial transmitter and receiver with a byte-wide register interface. A frame carries a start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. The bit rate comes from an external timer-overflow strobe. That strobe is halved unless the double-rate control is set, and the result is the oversampling tick, sixteen per bit.

In nine-bit frames the ninth bit tells an address frame (1) from a data frame (0). When address filtering is on, a listening node takes in and flags only address frames, and data frames leave its receive registers and receive flag alone. The receiver reports a stop bit that samples low as a framing error. That error can be shown on a shared status output in place of the frame-size mode bit. The transmit-done, receive-done and framing-error flags stay set until they are cleared.

Top module: `nine_bit_uart`

## Requirements
- R1: Under reset and directly after it, txd is 1, ti, ri and fe are 0, and rx_data and rx_bit9 are 0.
- R2: With frame9 = 0, a write while idle sends the frame low start bit, the eight tx_data bits LSB first, then a high stop bit. Each bit lasts 16 oversampling ticks. The low start bit shows the cycle after the write. ti sets at the clock edge that ends the stop bit.
- R3: With frame9 = 1, tx_bit9 is sent between the last data bit and the stop bit, which gives 11 bits.
- R4: A write while a frame is being sent has no effect on the line or on the frame in progress.
- R5: With dbl_rate = 1 every baud_tick is an oversampling tick. With dbl_rate = 0 only every second baud_tick counts, and the first baud_tick after reset does not.
- R6: The receiver starts on a 1-to-0 change of the synchronised rxd. If the start bit does not vote 0 at mid-bit, the receiver drops the frame and sets nothing.
- R7: Each bit is sampled at oversampling phases 7, 8 and 9 and decided by majority, so one wrong sample does not change the bit.
- R8: With frame9 = 0, a received frame loads rx_data and loads its stop bit into rx_bit9. ri sets at the phase-9 vote of the stop bit.
- R9: With frame9 = 1, rx_bit9 receives the ninth bit.
- R10: With frame9 = 1 and addr_filt = 1, a frame whose ninth bit is 0 leaves rx_data, rx_bit9 and ri unchanged. A frame whose ninth bit is 1 is delivered.
- R11: A stop bit that votes 0 sets fe, and fe holds until fe_clr.
- R12: mode_fe shows fe when fe_sel = 1 and frame9 when fe_sel = 0.
- R13: ti_clr, ri_clr and fe_clr clear their flags. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Timer-overflow strobe |
| dbl_rate | input | 1 | 1 bypasses the divide-by-2 of baud_tick |
| frame9 | input | 1 | 1 selects 11-bit frames with a ninth bit |
| addr_filt | input | 1 | Accept only address frames in nine-bit mode |
| fe_sel | input | 1 | Selects fe onto mode_fe |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send |
| ti_clr | input | 1 | Clear ti |
| ri_clr | input | 1 | Clear ri |
| fe_clr | input | 1 | Clear fe |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Received ninth bit, or the stop bit in 8-bit mode |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| fe | output | 1 | Framing-error flag |
| mode_fe | output | 1 | Shared status bit: fe or frame9 |

## Verification
When an oversampling tick comes every cycle, txd falls in the cycle after the write, and each bit spans 16 cycles. ti rises together with the return to idle at the end of the stop bit, 160 cycles after the write in 8-bit mode and 176 in nine-bit mode. A behavioural model predicts txd and ti and compares them on every falling clock edge. Counted from the falling edge on which the start bit is driven, three sync and detect stages place the phase-9 vote of bit k 13 + 16k cycles later. The bench therefore checks that ri is still low one cycle before the stop-bit vote, and checks ri, fe, rx_data and rx_bit9 at the vote. A dropped start is checked well after its 13-cycle verdict.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int DW        = 8;
    localparam int OSR       = 16;
    localparam int MID       = OSR / 2;
    localparam int PH_W      = $clog2(OSR);
    localparam int FRAME_W   = DW + 3;
    localparam int IDX_W     = $clog2(FRAME_W + 1);
    localparam int NFLAG     = 3;
    localparam int FLG_TI    = 0;
    localparam int FLG_RI    = 1;
    localparam int FLG_FE    = 2;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          nine;
        logic          stop;
        logic          wide;
    } rx_frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    // bit 0 is sent first
    function automatic logic [FRAME_W-1:0] pack_frame(input logic [DW-1:0] d,
                                                      input logic nine,
                                                      input logic wide);
        return {1'b1, (wide ? nine : 1'b1), d, 1'b0};
    endfunction

    function automatic logic [IDX_W-1:0] stop_index(input logic wide);
        return wide ? IDX_W'(DW + 2) : IDX_W'(DW + 1);
    endfunction
endpackage

// File: rtl/uart9_rate.sv
module uart9_rate (
    input  logic clk,
    input  logic rst,
    input  logic baud_tick,
    input  logic dbl_rate,
    output logic os_tick
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else if (baud_tick)
            half_q <= ~half_q;
    end

    assign os_tick = baud_tick & (dbl_rate | half_q);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          os_tick,
    input  logic          nine_en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          wnine,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    logic [FRAME_W-1:0] sh_q;
    logic [IDX_W-1:0]   idx_q, last_q, nxt_idx;
    logic [PH_W-1:0]    ph_q;
    logic               busy_q, txd_q, bit_end;

    assign nxt_idx = idx_q + 1'b1;
    assign bit_end = busy_q && os_tick && (ph_q == PH_W'(OSR - 1));
    assign done    = bit_end && (idx_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            idx_q  <= '0;
            last_q <= '0;
            ph_q   <= '0;
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
        end else if (!busy_q) begin
            if (wr) begin
                sh_q   <= pack_frame(wdata, wnine, nine_en);
                last_q <= stop_index(nine_en);
                idx_q  <= '0;
                ph_q   <= '0;
                busy_q <= 1'b1;
                txd_q  <= 1'b0;
            end
        end else if (os_tick) begin
            if (bit_end) begin
                ph_q <= '0;
                if (done) begin
                    busy_q <= 1'b0;
                    txd_q  <= 1'b1;
                end else begin
                    idx_q <= nxt_idx;
                    txd_q <= sh_q[nxt_idx];
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign txd  = txd_q;
    assign busy = busy_q;
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      os_tick,
    input  logic      rxd,
    input  logic      nine_en,
    output rx_frame_t frame,
    output logic      frame_ok
);
    logic             s1_q, s2_q, last_q, act_q, wide_q, nine_q;
    logic [PH_W-1:0]  ph_q;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       samp_q;
    logic [DW-1:0]    sh_q;
    logic             at_vote, at_stop, bit_v;

    assign at_vote  = os_tick && act_q && (ph_q == PH_W'(MID + 1));
    assign at_stop  = (idx_q == stop_index(wide_q));
    assign bit_v    = vote3({samp_q, s2_q});
    assign frame_ok = at_vote && at_stop;

    always_comb begin
        frame.data = sh_q;
        frame.nine = wide_q ? nine_q : bit_v;
        frame.stop = bit_v;
        frame.wide = wide_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            last_q <= 1'b1;
            act_q  <= 1'b0;
            wide_q <= 1'b0;
            nine_q <= 1'b0;
            ph_q   <= '0;
            idx_q  <= '0;
            samp_q <= '0;
            sh_q   <= '0;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (os_tick) begin
                last_q <= s2_q;
                if (!act_q) begin
                    if (!s2_q && last_q) begin
                        act_q  <= 1'b1;
                        ph_q   <= '0;
                        idx_q  <= '0;
                        wide_q <= nine_en;
                    end
                end else begin
                    if (ph_q == PH_W'(OSR - 1)) begin
                        ph_q  <= '0;
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                    if (ph_q == PH_W'(MID - 1) || ph_q == PH_W'(MID))
                        samp_q <= {samp_q[0], s2_q};
                    if (at_vote) begin
                        if (idx_q == '0) begin
                            if (bit_v)
                                act_q <= 1'b0;
                        end else if (idx_q <= IDX_W'(DW)) begin
                            sh_q <= {bit_v, sh_q[DW-1:1]};
                        end else if (at_stop) begin
                            act_q <= 1'b0;
                        end else begin
                            nine_q <= bit_v;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart9_flag.sv
module uart9_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end
endmodule

// File: rtl/nine_bit_uart.sv
module nine_bit_uart
    import uart9_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          dbl_rate,
    input  logic          frame9,
    input  logic          addr_filt,
    input  logic          fe_sel,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_bit9,
    input  logic          ti_clr,
    input  logic          ri_clr,
    input  logic          fe_clr,
    input  logic          rxd,
    output logic          txd,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          ti,
    output logic          ri,
    output logic          fe,
    output logic          mode_fe
);
    logic             os_tick, tx_busy, tx_done, rx_ok, rx_take;
    rx_frame_t        rx_f;
    logic [NFLAG-1:0] fl_set, fl_clr, fl_q;

    uart9_rate u_rate (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .dbl_rate(dbl_rate), .os_tick(os_tick)
    );

    uart9_tx u_tx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .nine_en(frame9),
        .wr(tx_wr), .wdata(tx_data), .wnine(tx_bit9),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart9_rx u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .nine_en(frame9), .frame(rx_f), .frame_ok(rx_ok)
    );

    // data frames are dropped by a filtering listener
    assign rx_take = rx_ok && !(rx_f.wide && addr_filt && !rx_f.nine);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
        end else if (rx_take) begin
            rx_data <= rx_f.data;
            rx_bit9 <= rx_f.nine;
        end
    end

    assign fl_set[FLG_TI] = tx_done;
    assign fl_set[FLG_RI] = rx_take;
    assign fl_set[FLG_FE] = rx_ok && !rx_f.stop;
    assign fl_clr[FLG_TI] = ti_clr;
    assign fl_clr[FLG_RI] = ri_clr;
    assign fl_clr[FLG_FE] = fe_clr;

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        uart9_flag u_flag (
            .clk(clk), .rst(rst), .set(fl_set[gi]),
            .clr(fl_clr[gi]), .q(fl_q[gi])
        );
    end

    assign ti      = fl_q[FLG_TI];
    assign ri      = fl_q[FLG_RI];
    assign fe      = fl_q[FLG_FE];
    assign mode_fe = fe_sel ? fe : frame9;
endmodule

// File: rtl/uart9_checker.sv
module uart9_checker
    import uart9_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          dbl_rate,
    input logic          os_tick,
    input logic          tx_busy,
    input logic          tx_wr,
    input logic          txd,
    input logic          ti,
    input logic          ti_clr,
    input logic          ri,
    input logic          ri_clr,
    input logic          ri_set,
    input logic          fe,
    input logic          fe_clr,
    input logic          rx_ok,
    input logic          rx_wide,
    input logic          rx_nine,
    input logic          addr_filt,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9
);
    a_r5_half_rate: assert property (@(posedge clk) disable iff (rst)
        (!dbl_rate && os_tick) |=> (dbl_rate || !os_tick));

    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    a_r4_busy_write: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_wr && !os_tick) |=> $stable(txd));

    a_r2_ti_hold: assert property (@(posedge clk) disable iff (rst)
        (ti && !ti_clr) |=> ti);

    a_r13_ri_clear: assert property (@(posedge clk) disable iff (rst)
        (ri_clr && !ri_set) |=> !ri);

    a_r11_fe_hold: assert property (@(posedge clk) disable iff (rst)
        (fe && !fe_clr) |=> fe);

    a_r10_keep_data: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_wide && addr_filt && !rx_nine) |=> ($stable(rx_data) && $stable(rx_bit9)));

    a_r10_keep_ri: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_wide && addr_filt && !rx_nine && !ri_clr) |=> $stable(ri));
endmodule

bind nine_bit_uart uart9_checker u_chk (
    .clk(clk), .rst(rst), .dbl_rate(dbl_rate), .os_tick(os_tick),
    .tx_busy(tx_busy), .tx_wr(tx_wr), .txd(txd), .ti(ti), .ti_clr(ti_clr),
    .ri(ri), .ri_clr(ri_clr), .ri_set(fl_set[uart9_pkg::FLG_RI]),
    .fe(fe), .fe_clr(fe_clr), .rx_ok(rx_ok), .rx_wide(rx_f.wide),
    .rx_nine(rx_f.nine), .addr_filt(addr_filt), .rx_data(rx_data),
    .rx_bit9(rx_bit9)
);

// File: tb/nine_bit_uart_test.sv
module nine_bit_uart_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b1, dbl_rate = 1'b1, frame9 = 1'b0;
    logic       addr_filt = 1'b0, fe_sel = 1'b0, tx_wr = 1'b0, tx_bit9 = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       ti_clr = 1'b0, ri_clr = 1'b0, fe_clr = 1'b0, rxd = 1'b1;
    logic       txd, rx_bit9, ti, ri, fe, mode_fe;
    logic [7:0] rx_data;

    int    n_chk = 0, n_bad = 0;
    bit    finished = 1'b0;
    string m_tag = "R1";
    logic [7:0] exp_data = 8'h00;
    logic       exp_bit9 = 1'b0;

    always #5 clk = ~clk;

    nine_bit_uart uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .dbl_rate(dbl_rate),
        .frame9(frame9), .addr_filt(addr_filt), .fe_sel(fe_sel),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9),
        .ti_clr(ti_clr), .ri_clr(ri_clr), .fe_clr(fe_clr), .rxd(rxd),
        .txd(txd), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .ti(ti), .ri(ri), .fe(fe), .mode_fe(mode_fe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural transmit model
    bit m_half = 0, m_busy = 0, m_txd = 1, m_ti = 0;
    bit m_bits[$];
    int m_pos = 0, m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_half = 0; m_busy = 0; m_txd = 1; m_ti = 0;
        end else begin
            bit os, tdone;
            os = baud_tick && (dbl_rate || m_half);
            if (baud_tick) m_half = !m_half;
            tdone = 0;
            if (!m_busy) begin
                if (tx_wr) begin
                    m_bits.delete();
                    m_bits.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_bits.push_back(tx_data[i]);
                    if (frame9) m_bits.push_back(tx_bit9);
                    m_bits.push_back(1'b1);
                    m_busy = 1; m_pos = 0; m_cnt = 0; m_txd = 0;
                end
            end else if (os) begin
                if (m_cnt == 15) begin
                    m_cnt = 0;
                    m_pos++;
                    if (m_pos == m_bits.size()) begin
                        m_busy = 0; m_txd = 1; tdone = 1;
                    end else begin
                        m_txd = m_bits[m_pos];
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (tdone) m_ti = 1;
            else if (ti_clr) m_ti = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(txd === m_txd, m_tag, txd, m_txd);
            chk(ti === m_ti, m_tag, ti, m_ti);
        end
    end

    task automatic tx_send(input logic [7:0] d, input logic nine);
        @(negedge clk);
        tx_data = d; tx_bit9 = nine; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic clr_ti();
        @(negedge clk); ti_clr = 1'b1;
        @(negedge clk); ti_clr = 1'b0;
    endtask

    // drives one frame; bit k occupies negedges 16k..16k+15
    task automatic rx_frame(input logic [7:0] d, input logic nine, input logic wide,
                            input logic stopv, input int gk, input bit hold_clr,
                            input string tag);
        bit bits[$];
        int s;
        bit take;
        @(negedge clk); ri_clr = 1'b1; fe_clr = 1'b1;
        @(negedge clk); ri_clr = hold_clr; fe_clr = 1'b0;
        repeat (2) @(negedge clk);
        bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) bits.push_back(d[i]);
        if (wide) bits.push_back(nine);
        bits.push_back(stopv);
        s = bits.size() - 1;
        take = !(wide && addr_filt && !nine);
        if (take) begin
            exp_data = d;
            exp_bit9 = wide ? nine : stopv;
        end
        for (int j = 0; j < 16 * (s + 1); j++) begin
            if (j > 0) @(negedge clk);
            rxd = bits[j / 16] ^ ((j / 16 == gk) && (j % 16 == 9));
            if (j == 12 + 16 * s) begin
                chk(ri === 1'b0, tag, ri, 0);
            end
            if (j == 13 + 16 * s) begin
                chk(ri === take, tag, ri, take);
                chk(rx_data === exp_data, tag, rx_data, exp_data);
                chk(rx_bit9 === exp_bit9, tag, rx_bit9, exp_bit9);
                chk(fe === !stopv, tag, fe, !stopv);
            end
            if (hold_clr && j == 14 + 16 * s) begin
                chk(ri === 1'b0, "R13", ri, 0);
            end
        end
        @(negedge clk);
        rxd = 1'b1; ri_clr = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && ti === 1'b0 && ri === 1'b0 && fe === 1'b0, "R1", {txd, ti, ri, fe}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R1", txd, 1);
        chk({ti, ri, fe} === 3'b000, "R1", {ti, ri, fe}, 0);
        chk(rx_data === 8'h00 && rx_bit9 === 1'b0, "R1", {rx_bit9, rx_data}, 0);

        m_tag = "R2";
        tx_send(8'hA5, 1'b0);
        repeat (170) @(negedge clk);
        chk(ti === 1'b1, "R2", ti, 1);
        clr_ti();
        chk(ti === 1'b0, "R13", ti, 0);

        m_tag = "R4";
        tx_send(8'h3C, 1'b0);
        repeat (40) @(negedge clk);
        tx_send(8'hFF, 1'b0);
        repeat (130) @(negedge clk);
        clr_ti();

        m_tag = "R3";
        frame9 = 1'b1;
        tx_send(8'h5A, 1'b1);
        repeat (185) @(negedge clk);
        tx_send(8'hC3, 1'b0);
        repeat (185) @(negedge clk);
        clr_ti();

        m_tag = "R5";
        frame9 = 1'b0; dbl_rate = 1'b0;
        tx_send(8'h81, 1'b0);
        repeat (340) @(negedge clk);
        chk(ti === 1'b1, "R5", ti, 1);
        dbl_rate = 1'b1;
        clr_ti();

        m_tag = "R8";
        rx_frame(8'h96, 1'b0, 1'b0, 1'b1, -1, 1'b0, "R8");

        // start pulse too short to survive the mid-bit vote
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(ri === 1'b1, "R6", ri, 1);
        @(negedge clk); ri_clr = 1'b1;
        @(negedge clk); ri_clr = 1'b0;
        @(negedge clk); rxd = 1'b0;
        repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk(ri === 1'b0, "R6", ri, 0);
        chk(rx_data === exp_data, "R6", rx_data, exp_data);

        rx_frame(8'h4B, 1'b0, 1'b0, 1'b1, 3, 1'b0, "R7");
        rx_frame(8'hB4, 1'b0, 1'b0, 1'b1, 8, 1'b0, "R7");

        frame9 = 1'b1;
        rx_frame(8'hE1, 1'b1, 1'b1, 1'b1, -1, 1'b0, "R9");
        rx_frame(8'h1E, 1'b0, 1'b1, 1'b1, -1, 1'b0, "R9");
        addr_filt = 1'b1;
        rx_frame(8'h22, 1'b0, 1'b1, 1'b1, -1, 1'b0, "R10");
        rx_frame(8'h7E, 1'b1, 1'b1, 1'b1, -1, 1'b0, "R10");
        addr_filt = 1'b0; frame9 = 1'b0;

        rx_frame(8'h33, 1'b0, 1'b0, 1'b0, -1, 1'b0, "R11");
        repeat (30) @(negedge clk);
        chk(fe === 1'b1, "R11", fe, 1);
        fe_sel = 1'b1;
        @(negedge clk);
        chk(mode_fe === 1'b1, "R12", mode_fe, 1);
        fe_sel = 1'b0;
        @(negedge clk);
        chk(mode_fe === 1'b0, "R12", mode_fe, 0);
        frame9 = 1'b1;
        @(negedge clk);
        chk(mode_fe === 1'b1, "R12", mode_fe, 1);
        frame9 = 1'b0;
        @(negedge clk); fe_clr = 1'b1;
        @(negedge clk); fe_clr = 1'b0;
        chk(fe === 1'b0, "R11", fe, 0);
        fe_sel = 1'b1;
        @(negedge clk);
        chk(mode_fe === 1'b0, "R12", mode_fe, 0);
        fe_sel = 1'b0;

        rx_frame(8'hC8, 1'b0, 1'b0, 1'b1, -1, 1'b1, "R13");

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule